// File: doc/BRIEF.md
# Three-Wire Control Bus Slave Receiver

This block sits on the slave side of a three-wire control bus. The bus has a framing line, a bit clock and a shared data line. The controller drives the framing line and the bit clock. The data line carries bits in either direction. The block runs on its own system clock and samples all three lines through two-flop synchronisers. It acts on the edges it finds in the synchronised levels.

Pulling the framing line low starts a select phase. During that phase one byte arrives, least significant bit first, and the block captures one bit on each rising edge of the bit clock. When the framing line returns high, the byte is split into two fields: a six-bit target address and a two-bit operation code. The block becomes selected only when both of these hold:
- exactly eight bit-clock pulses were seen;
- the target address is non-zero and equals the strap address.

While selected, the block carries out one transfer phase in one fixed direction:
- In a write phase, every received byte appears as a one-cycle pulse on a valid/data port.
- In a read phase, bytes taken from a parallel input are shifted out on the data line under an output enable.

Top module: `ctl3w_slave`

## Requirements
- R1: After reset, `sel_o`, `bus_dat_oe`, `wr_valid_o` and `rd_take_o` are low and `op_o` is 0.
- R2: When the framing line rises after a select phase with exactly eight rising bit-clock edges, and the received address is non-zero and equal to `dev_addr_i`, `sel_o` goes high within 4 system clocks.
- R3: The first bit received in a select phase is bit 0 of the byte. Bits [1:0] are the operation code and are reported on `op_o` once selected. Bits [7:2] are the target address.
- R4: In a selected phase with `op_o[0]`=0 (write), every 8 rising bit-clock edges give one `wr_valid_o` pulse lasting a single cycle. `wr_data_o` then holds the byte, built least significant bit first.
- R5: After a select phase whose address differs from `dev_addr_i`, `sel_o` and `bus_dat_oe` stay low and no `wr_valid_o` pulse occurs.
- R6: A received address of zero never selects the block, even when `dev_addr_i` is zero.
- R7: A select phase with fewer or more than eight bit-clock pulses is discarded. Because every select phase first clears any earlier selection, the block ends unselected.
- R8: In a selected phase with `op_o[0]`=1 (read), `bus_dat_oe` is high. The current bit is on `bus_dat_o` at every rising bit-clock edge, least significant bit first, and the next bit is presented after each falling edge.
- R9: In a read phase, `rd_take_o` pulses once each time a byte is loaded from `rd_data_i`: once at the start of the phase, and again on the falling edge that follows every eighth rising edge.
- R10: The direction is locked for the whole phase. A read phase produces no `wr_valid_o`, and a write phase never raises `bus_dat_oe`.
- R11: A falling framing line ends the transfer phase. `sel_o` and `bus_dat_oe` drop within 4 system clocks, and a partial byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_mode_i | input | 1 | Framing line, low during select phase |
| bus_clk_i | input | 1 | Bit clock, idles high |
| bus_dat_i | input | 1 | Data line as seen at the pin |
| bus_dat_o | output | 1 | Data line value driven in read phase |
| bus_dat_oe | output | 1 | Tristate enable for the data line |
| dev_addr_i | input | 6 | Strap-configured device address |
| sel_o | output | 1 | Block selected for the current transfer phase |
| op_o | output | 2 | Operation code of the current selection |
| wr_valid_o | output | 1 | One-cycle pulse: received write byte valid |
| wr_data_o | output | 8 | Received write byte |
| rd_data_i | input | 8 | Byte to send in read phase |
| rd_take_o | output | 1 | Pulse: `rd_data_i` has been loaded |

## Verification
Faults inside the block show up at the ports within one bus byte:
- A wrong select-phase bit count or a bad address comparison shows on `sel_o` a few system clocks after the framing line rises.
- A slipped write shift or counter produces a wrong or missing `wr_valid_o` byte by the eighth rising edge.
- A read shifter that advances on the wrong edge puts a wrong bit on `bus_dat_o` at the very next rising edge.
- A selection that is not cleared when the framing line falls leaves `bus_dat_oe` high, or yields stray write pulses, during the following phase.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
  localparam int ADDR_W = 6;
  localparam int OP_W   = 2;
  localparam int BYTE_W = ADDR_W + OP_W;

  // line index into the synchroniser bank
  localparam int LN_MODE = 0;
  localparam int LN_CLK  = 1;
  localparam int LN_DAT  = 2;
  localparam int LINES   = 3;

  function automatic logic op_is_read(input logic [OP_W-1:0] op);
    return op[0];
  endfunction
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
  parameter int LINES  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] rise_o,
  output logic [LINES-1:0] fall_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    logic              prev;
    always_ff @(posedge clk) begin
      if (rst) begin
        pipe <= '1;
        prev <= 1'b1;
      end else begin
        pipe <= {pipe[STAGES-2:0], raw_i[g]};
        prev <= pipe[STAGES-1];
      end
    end
    assign lvl_o[g]  = pipe[STAGES-1];
    assign rise_o[g] = pipe[STAGES-1] & ~prev;
    assign fall_o[g] = ~pipe[STAGES-1] & prev;
  end
endmodule

// File: rtl/ctl3w_addr.sv
module ctl3w_addr
  import ctl3w_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int OW = OP_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_fall,
  input  logic          mode_rise,
  input  logic          mode_lvl,
  input  logic          bclk_rise,
  input  logic          dat,
  input  logic [AW-1:0] dev_addr,
  output logic          sel_o,
  output logic [OW-1:0] op_o,
  output logic          start_o
);
  localparam int BW    = AW + OW;
  localparam int CNT_W = $clog2(BW + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BW);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(BW + 1);

  logic [BW-1:0]    shreg;
  logic [CNT_W-1:0] cnt;
  logic             hit;

  assign hit = (cnt == CNT_FULL) && (shreg[BW-1:OW] == dev_addr) && (|shreg[BW-1:OW]);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      cnt     <= '0;
      sel_o   <= 1'b0;
      op_o    <= '0;
      start_o <= 1'b0;
    end else begin
      start_o <= 1'b0;
      if (mode_fall) begin
        shreg <= '0;
        cnt   <= '0;
        sel_o <= 1'b0;
      end else if (!mode_lvl && bclk_rise) begin
        shreg <= {dat, shreg[BW-1:1]};
        if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
      end else if (mode_rise) begin
        sel_o   <= hit;
        start_o <= hit;
        if (hit) op_o <= shreg[OW-1:0];
      end
    end
  end

  p_sel_on_frame_end_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_o) |-> $past(mode_rise));
  p_zero_addr_never_r6: assert property (@(posedge clk) disable iff (rst)
    sel_o |-> (dev_addr != '0));
  p_drop_on_frame_r11: assert property (@(posedge clk) disable iff (rst)
    mode_fall |=> !sel_o);
endmodule

// File: rtl/ctl3w_data.sv
module ctl3w_data
  import ctl3w_pkg::*;
#(
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_lvl,
  input  logic          mode_fall,
  input  logic          bclk_rise,
  input  logic          bclk_fall,
  input  logic          dat,
  input  logic          start,
  input  logic          sel,
  input  logic          rd_dir,
  input  logic [DW-1:0] rd_data,
  output logic          wr_valid_o,
  output logic [DW-1:0] wr_data_o,
  output logic          rd_take_o,
  output logic          dat_o,
  output logic          oe_o
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  // write engine
  logic [DW-1:0] wsh;
  logic [CW-1:0] wcnt;
  logic          wr_act;
  assign wr_act = sel & ~rd_dir & mode_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      wsh        <= '0;
      wcnt       <= '0;
      wr_valid_o <= 1'b0;
      wr_data_o  <= '0;
    end else begin
      wr_valid_o <= 1'b0;
      if (mode_fall) begin
        wcnt <= '0;
      end else if (wr_act && bclk_rise) begin
        wsh <= {dat, wsh[DW-1:1]};
        if (wcnt == LAST) begin
          wcnt       <= '0;
          wr_valid_o <= 1'b1;
          wr_data_o  <= {dat, wsh[DW-1:1]};
        end else begin
          wcnt <= wcnt + 1'b1;
        end
      end
    end
  end

  // read engine
  logic [DW-1:0] rsh;
  logic [CW-1:0] rcnt;
  logic          pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsh       <= '0;
      rcnt      <= '0;
      pend      <= 1'b0;
      oe_o      <= 1'b0;
      rd_take_o <= 1'b0;
    end else begin
      rd_take_o <= 1'b0;
      if (mode_fall) begin
        oe_o <= 1'b0;
        pend <= 1'b0;
        rcnt <= '0;
      end else if (start && rd_dir) begin
        oe_o      <= 1'b1;
        rsh       <= rd_data;
        rd_take_o <= 1'b1;
        rcnt      <= '0;
        pend      <= 1'b0;
      end else if (oe_o && bclk_rise) begin
        pend <= 1'b1;
      end else if (oe_o && bclk_fall && pend) begin
        pend <= 1'b0;
        if (rcnt == LAST) begin
          rsh       <= rd_data;
          rd_take_o <= 1'b1;
          rcnt      <= '0;
        end else begin
          rsh  <= {1'b0, rsh[DW-1:1]};
          rcnt <= rcnt + 1'b1;
        end
      end
    end
  end

  assign dat_o = rsh[0];

  p_no_write_in_read_r10: assert property (@(posedge clk) disable iff (rst)
    wr_valid_o |-> (sel && !rd_dir));
  p_write_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    wr_valid_o |=> !wr_valid_o);
  p_oe_needs_sel_r8: assert property (@(posedge clk) disable iff (rst)
    oe_o |-> sel);
  p_take_in_read_r9: assert property (@(posedge clk) disable iff (rst)
    rd_take_o |-> (oe_o && rd_dir));
  p_bit_stable_at_rise_r8: assert property (@(posedge clk) disable iff (rst)
    (oe_o && bclk_rise) |=> $stable(dat_o));
endmodule

// File: rtl/ctl3w_slave.sv
module ctl3w_slave
  import ctl3w_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_mode_i,
  input  logic              bus_clk_i,
  input  logic              bus_dat_i,
  output logic              bus_dat_o,
  output logic              bus_dat_oe,
  input  logic [ADDR_W-1:0] dev_addr_i,
  output logic              sel_o,
  output logic [OP_W-1:0]   op_o,
  output logic              wr_valid_o,
  output logic [BYTE_W-1:0] wr_data_o,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              rd_take_o
);
  logic [LINES-1:0] lvl, rise, fall;
  logic             start;

  ctl3w_sync #(.LINES(LINES), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst),
    .raw_i({bus_dat_i, bus_clk_i, bus_mode_i}),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  ctl3w_addr #(.AW(ADDR_W), .OW(OP_W)) i_addr (
    .clk(clk), .rst(rst),
    .mode_fall(fall[LN_MODE]), .mode_rise(rise[LN_MODE]), .mode_lvl(lvl[LN_MODE]),
    .bclk_rise(rise[LN_CLK]), .dat(lvl[LN_DAT]),
    .dev_addr(dev_addr_i),
    .sel_o(sel_o), .op_o(op_o), .start_o(start)
  );

  ctl3w_data #(.DW(BYTE_W)) i_data (
    .clk(clk), .rst(rst),
    .mode_lvl(lvl[LN_MODE]), .mode_fall(fall[LN_MODE]),
    .bclk_rise(rise[LN_CLK]), .bclk_fall(fall[LN_CLK]),
    .dat(lvl[LN_DAT]),
    .start(start), .sel(sel_o), .rd_dir(op_is_read(op_o)),
    .rd_data(rd_data_i),
    .wr_valid_o(wr_valid_o), .wr_data_o(wr_data_o),
    .rd_take_o(rd_take_o), .dat_o(bus_dat_o), .oe_o(bus_dat_oe)
  );

  p_write_never_drives_r10: assert property (@(posedge clk) disable iff (rst)
    (sel_o && !op_o[0]) |-> !bus_dat_oe);
endmodule

// File: tb/test_ctl3w_slave.sv
module test_ctl3w_slave;
  localparam int CLK_PERIOD = 10;
  localparam int H = 6;
  localparam logic [5:0] MY_ADDR = 6'h2D;

  logic clk = 0, rst = 1;
  logic bmode = 1, bclk = 1, bdat = 1;
  logic bdo, boe, sel, wv, take;
  logic [5:0] dev_addr = MY_ADDR;
  logic [1:0] op;
  logic [7:0] wdat, rdv = 8'h3C;

  int checks = 0, fails = 0, wr_pulses = 0, takes = 0;
  logic [7:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl3w_slave i_ctl3w_slave (
    .clk(clk), .rst(rst), .bus_mode_i(bmode), .bus_clk_i(bclk), .bus_dat_i(bdat),
    .bus_dat_o(bdo), .bus_dat_oe(boe), .dev_addr_i(dev_addr), .sel_o(sel), .op_o(op),
    .wr_valid_o(wv), .wr_data_o(wdat), .rd_data_i(rdv), .rd_take_o(take)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && wv) begin
      wr_pulses++;
      checks++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL R5/R10 unexpected write byte actual=%0h expected=none", wdat);
      end else begin
        logic [7:0] e;
        e = expq.pop_front();
        if (wdat !== e) begin
          fails++;
          $display("FAIL R4 write byte actual=%0h expected=%0h", wdat, e);
        end
      end
    end
    if (!rst && take) begin
      takes++;
      rdv <= rdv + 8'h1;
    end
  end

  task automatic send_bits(input logic [15:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      bclk = 0; bdat = v[i]; step(H);
      bclk = 1; step(H);
    end
  endtask

  task automatic addr_phase(input logic [7:0] b, input int n);
    bmode = 0; step(H);
    send_bits({8'h00, b}, n);
    bmode = 1; step(H);
  endtask

  task automatic wr_byte(input logic [7:0] b, input logic expect_it);
    if (expect_it) expq.push_back(b);
    send_bits({8'h00, b}, 8);
  endtask

  task automatic rd_byte(input logic [7:0] exp);
    logic [7:0] got;
    for (int i = 0; i < 8; i++) begin
      bclk = 0; step(H);
      bclk = 1;
      got[i] = bdo;
      chk("R8 oe during read", boe, 1);
      step(H);
    end
    chk("R8 read byte", got, exp);
  endtask

  initial begin
    step(4);
    rst = 0; step(2);
    // R1 reset state
    chk("R1 sel", sel, 0); chk("R1 oe", boe, 0); chk("R1 wv", wv, 0);
    chk("R1 take", take, 0); chk("R1 op", op, 0);

    // R2/R3/R4 write with op 2
    addr_phase({MY_ADDR, 2'b10}, 8);
    chk("R2 selected", sel, 1); chk("R3 op field", op, 2);
    chk("R10 no oe in write", boe, 0);
    wr_byte(8'hA5, 1); wr_byte(8'h01, 1); wr_byte(8'h80, 1);
    chk("R10 no oe in write end", boe, 0);
    send_bits(16'h0005, 3); // partial byte
    bmode = 0; step(H);
    chk("R11 sel dropped", sel, 0);
    bmode = 1; step(H);
    chk("R4 write count", wr_pulses, 3);
    chk("R11 partial dropped", expq.size(), 0);

    // R5 mismatch
    addr_phase({6'h2C, 2'b00}, 8);
    chk("R5 sel low", sel, 0);
    wr_byte(8'h77, 0);
    chk("R5 oe low", boe, 0);
    chk("R5 no write", wr_pulses, 3);

    // R7 short and long select phases, after a valid selection
    addr_phase({MY_ADDR, 2'b00}, 8);
    chk("R2 reselect", sel, 1);
    addr_phase({MY_ADDR, 2'b00}, 7);
    chk("R7 seven pulses", sel, 0);
    addr_phase({MY_ADDR, 2'b00}, 9);
    chk("R7 nine pulses", sel, 0);
    wr_byte(8'h55, 0);
    chk("R7 no write", wr_pulses, 3);

    // R6 zero address with zero strap
    dev_addr = 6'h00; step(2);
    addr_phase(8'h00, 8);
    chk("R6 zero addr", sel, 0);
    dev_addr = MY_ADDR; step(2);

    // R8/R9/R10 read
    rdv = 8'h3C;
    addr_phase({MY_ADDR, 2'b01}, 8);
    chk("R2 read select", sel, 1); chk("R3 read op", op, 1);
    chk("R8 oe on", boe, 1);
    chk("R9 first take", takes, 1);
    rd_byte(8'h3C);
    rd_byte(8'h3D);
    chk("R9 take count", takes, 2);
    chk("R10 no write in read", wr_pulses, 3);
    bmode = 0; step(H);
    chk("R11 oe off", boe, 0); chk("R11 sel off", sel, 0);
    bmode = 1; step(H);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule